// File: doc/BRIEF.md
# Input Current Limit Soft-Start Sequencer

This block ramps the input current limit handed to a charger's analog input loop each time the charger comes out of its high-impedance state. The programmed limit code is not applied at full value right away. The block first passes on 40% of it for a long settling hold. It then raises the fraction in short, equal steps: 50%, 60%, 70%, 80%, and finally a jump to 100%. Once the full value is reached, a done flag rises. That state lasts until the charger goes back into high impedance, which re-arms the sequence.

Hold and step lengths are given in microseconds and turned into clock-cycle counts from the clock frequency parameter. The scaled code is worked out every cycle from the live programmed code. A change to the programmed limit in the middle of a ramp is therefore applied at once at the fraction currently in force. While high impedance is requested, the output and the done flag are held at zero.

Top module: `ilim_softstart`

## Requirements
- R1: While reset is asserted (active low), `ilim_eff_o` is 0 and `ss_done_o` is 0.
- R2: While `hiz_i` is 1, `ilim_eff_o` is 0 and `ss_done_o` is 0 in the same cycle, whatever the programmed code.
- R3: The first clock edge that samples `hiz_i` = 0 after high impedance or reset starts a ramp. From that edge on, the output is 40% of the programmed code.
- R4: The 40% fraction lasts exactly HOLD_CYC = CLK_HZ*HOLD_US/1e6 clock cycles, counted from the starting edge.
- R5: After the hold, the fraction takes the values 50, 60, 70 and 80 percent in that order, each for exactly STEP_CYC = CLK_HZ*STEP_US/1e6 cycles, and then moves to 100%.
- R6: `ss_done_o` is 1 exactly when the fraction is 100% and `hiz_i` is 0. In that state `ilim_eff_o` equals `ilim_code_i`.
- R7: `ilim_eff_o` equals floor(`ilim_code_i` * pct / 100), where pct is the fraction currently in force.
- R8: A change of `ilim_code_i` shows on `ilim_eff_o` in the same cycle, scaled by the current fraction, and does not disturb the step timing.
- R9: Once done, the block stays at 100% while `hiz_i` stays 0. Any cycle of `hiz_i` = 1, including one in the middle of a ramp, aborts the ramp. The next release restarts from 40% with a full hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| hiz_i | input | 1 | High-impedance request; 1 forces the output off and re-arms the ramp |
| ilim_code_i | input | CODE_W | Programmed input current limit code |
| ilim_eff_o | output | CODE_W | Effective (scaled) input current limit code |
| ss_done_o | output | 1 | Soft start complete: the full programmed code is in force |

## Verification
The bench follows whole ramps cycle by cycle. It goes after the boundary cycles at the end of the hold and between steps: a counter off by one would shift every later step by one cycle, and a schedule with uniform steps would show 90% where 100% is due. It sweeps every code value both at full scale and while the ramp is running. That sweep exposes rounding where truncation is required, and a registered output that would lag a code change by a cycle. It also aborts a ramp part way through. A sequencer that resumed where it left off, or that only re-armed after reaching done, would then skip the full 40% hold.

// File: rtl/ilim_ss_pkg.sv
package ilim_ss_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_P40  = 3'd1,
    ST_P50  = 3'd2,
    ST_P60  = 3'd3,
    ST_P70  = 3'd4,
    ST_P80  = 3'd5,
    ST_FULL = 3'd6
  } ss_stage_e;

  localparam int unsigned PCT_W = 7;

  // Fraction (percent) in force for a given stage.
  function automatic logic [PCT_W-1:0] stage_pct(input ss_stage_e s);
    case (s)
      ST_P40:  return 7'd40;
      ST_P50:  return 7'd50;
      ST_P60:  return 7'd60;
      ST_P70:  return 7'd70;
      ST_P80:  return 7'd80;
      ST_FULL: return 7'd100;
      default: return 7'd0;
    endcase
  endfunction

  // Stage reached when the timer expires in stage s.
  function automatic ss_stage_e stage_next(input ss_stage_e s);
    case (s)
      ST_P40:  return ST_P50;
      ST_P50:  return ST_P60;
      ST_P60:  return ST_P70;
      ST_P70:  return ST_P80;
      ST_P80:  return ST_FULL;
      ST_FULL: return ST_FULL;
      default: return ST_OFF;
    endcase
  endfunction

  // True for stages whose dwell is measured by the step interval.
  function automatic logic stage_is_step(input ss_stage_e s);
    return (s == ST_P50) || (s == ST_P60) || (s == ST_P70) || (s == ST_P80);
  endfunction

endpackage

// File: rtl/ilim_ss_timer.sv
module ilim_ss_timer #(
  parameter int unsigned HOLD_CYC = 80000,
  parameter int unsigned STEP_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic long_mode,
  input  logic short_mode,
  output logic tick
);
  localparam int unsigned MAX_CYC = (HOLD_CYC > STEP_CYC) ? HOLD_CYC : STEP_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit_hold;
  logic             hit_step;

  assign hit_hold = long_mode  && (cnt_q == HOLD_LAST);
  assign hit_step = short_mode && (cnt_q == STEP_LAST);
  assign tick     = !clear && (hit_hold || hit_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ilim_ss_seq.sv
module ilim_ss_seq
  import ilim_ss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hiz,
  input  logic      tick,
  output ss_stage_e stage,
  output logic      timer_clear,
  output logic      in_hold,
  output logic      in_step
);
  ss_stage_e stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_OFF;
    end else if (hiz) begin
      stage_q <= ST_OFF;
    end else if (stage_q == ST_OFF) begin
      stage_q <= ST_P40;
    end else if (tick) begin
      stage_q <= stage_next(stage_q);
    end
  end

  assign stage       = stage_q;
  assign in_hold     = (stage_q == ST_P40);
  assign in_step     = stage_is_step(stage_q);
  assign timer_clear = hiz || !(in_hold || in_step);
endmodule

// File: rtl/ilim_ss_scale.sv
module ilim_ss_scale
  import ilim_ss_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic [PCT_W-1:0]  pct,
  input  logic              force_off,
  output logic [CODE_W-1:0] scaled
);
  localparam int unsigned PROD_W = CODE_W + PCT_W;

  // floor(code * pct / 100); never exceeds code for pct <= 100.
  function automatic logic [CODE_W-1:0] scale_code(input logic [CODE_W-1:0] c,
                                                   input logic [PCT_W-1:0]  p);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    prod = PROD_W'(c) * PROD_W'(p);
    quo  = prod / PROD_W'(100);
    return quo[CODE_W-1:0];
  endfunction

  assign scaled = force_off ? '0 : scale_code(code, pct);
endmodule

// File: rtl/ilim_softstart.sv
module ilim_softstart
  import ilim_ss_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 1_000_000,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned HOLD_US = 80_000,
  parameter int unsigned STEP_US = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hiz_i,
  input  logic [CODE_W-1:0] ilim_code_i,
  output logic [CODE_W-1:0] ilim_eff_o,
  output logic              ss_done_o
);
  localparam longint unsigned HOLD_RAW = (longint'(CLK_HZ) * longint'(HOLD_US)) / 1_000_000;
  localparam longint unsigned STEP_RAW = (longint'(CLK_HZ) * longint'(STEP_US)) / 1_000_000;
  localparam int unsigned HOLD_CYC = (HOLD_RAW < 1) ? 1 : int'(HOLD_RAW);
  localparam int unsigned STEP_CYC = (STEP_RAW < 1) ? 1 : int'(STEP_RAW);

  // Named internal events, observed by the bound checker.
  ss_stage_e        stage;
  logic             tick;
  logic             timer_clear;
  logic             in_hold;
  logic             in_step;
  logic [PCT_W-1:0] cur_pct;

  ilim_ss_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hiz        (hiz_i),
    .tick       (tick),
    .stage      (stage),
    .timer_clear(timer_clear),
    .in_hold    (in_hold),
    .in_step    (in_step)
  );

  ilim_ss_timer #(
    .HOLD_CYC(HOLD_CYC),
    .STEP_CYC(STEP_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (timer_clear),
    .long_mode (in_hold),
    .short_mode(in_step),
    .tick      (tick)
  );

  assign cur_pct = stage_pct(stage);

  ilim_ss_scale #(
    .CODE_W(CODE_W)
  ) u_scale (
    .code     (ilim_code_i),
    .pct      (cur_pct),
    .force_off(hiz_i || !rst_n),
    .scaled   (ilim_eff_o)
  );

  assign ss_done_o = rst_n && !hiz_i && (stage == ST_FULL);
endmodule

// File: rtl/ilim_softstart_chk.sv
module ilim_softstart_chk
  import ilim_ss_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hiz_i,
  input logic [CODE_W-1:0] ilim_code_i,
  input logic [CODE_W-1:0] ilim_eff_o,
  input logic              ss_done_o,
  input ss_stage_e         stage,
  input logic              tick,
  input logic [PCT_W-1:0]  cur_pct
);
  AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |-> (ilim_eff_o == '0) && !ss_done_o); // R2

  AST_START_FORTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_i && stage == ST_OFF) |=> (cur_pct == 7'd40)); // R3

  AST_DWELL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_i && !tick && stage != ST_OFF) |=> $stable(stage)); // R4

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done_o |-> (ilim_eff_o == ilim_code_i)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_eff_o <= ilim_code_i); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_FULL && !hiz_i) |=> (stage == ST_FULL)); // R9

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |=> (stage == ST_OFF)); // R9
endmodule

bind ilim_softstart ilim_softstart_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hiz_i      (hiz_i),
  .ilim_code_i(ilim_code_i),
  .ilim_eff_o (ilim_eff_o),
  .ss_done_o  (ss_done_o),
  .stage      (stage),
  .tick       (tick),
  .cur_pct    (cur_pct)
);

// File: tb/ilim_softstart_bench.sv
module ilim_softstart_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ     = 125_000;
  localparam int unsigned CODE_W     = 8;
  // Expected timing, restated from the requirements: 80 ms and 256 us at 125 kHz.
  localparam int unsigned T_HOLD = 10000;
  localparam int unsigned T_STEP = 32;
  localparam int unsigned T_RAMP = T_HOLD + 4 * T_STEP;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hiz = 1'b1;
  logic [CODE_W-1:0] code = '0;
  logic [CODE_W-1:0] lim;
  logic              done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  ilim_softstart #(
    .CLK_HZ (CLK_HZ),
    .CODE_W (CODE_W),
    .HOLD_US(80_000),
    .STEP_US(256)
  ) u_ilim_softstart (
    .clk        (clk),
    .rst_n      (rst_n),
    .hiz_i      (hiz),
    .ilim_code_i(code),
    .ilim_eff_o (lim),
    .ss_done_o  (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_pct(input int t);
    int k;
    if (t < int'(T_HOLD)) return 40;
    k = (t - int'(T_HOLD)) / int'(T_STEP);
    case (k)
      0: return 50;
      1: return 60;
      2: return 70;
      3: return 80;
      default: return 100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Runs ncyc edges of a ramp begun at the next edge; t counts from 0.
  task automatic run_ramp(input int ncyc, input bit vary, input string req);
    for (int n = 0; n < ncyc; n++) begin
      int p;
      int e;
      @(posedge clk);
      @(negedge clk);
      if (vary) code = CODE_W'((n * 37 + 11) % 256); // R8 code moves mid-ramp
      #1;
      p = exp_pct(n);
      e = (int'(code) * p) / 100;
      check(lim == CODE_W'(e), req, int'(lim), e);
      check(done == (p == 100), {req, " R6 done"}, int'(done), int'(p == 100));
    end
  endtask

  initial begin
    // R1: reset state
    code = 8'd200;
    repeat (3) @(negedge clk);
    check(lim == 0, "R1 lim", int'(lim), 0);
    check(done == 0, "R1 done", int'(done), 0);
    rst_n = 1'b1;

    // R2: high impedance keeps everything off for any code
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      code = CODE_W'(c * 4 + 3);
      #1;
      check(lim == 0, "R2 lim", int'(lim), 0);
      check(done == 0, "R2 done", int'(done), 0);
    end

    // R3 R4 R5 R6: full ramp with a fixed code
    @(negedge clk);
    code = 8'd200;
    hiz = 1'b0;
    run_ramp(T_RAMP + 40, 1'b0, "R3/R4/R5 fixed");

    // R6 R7: every code at full scale
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      code = CODE_W'(c);
      #1;
      check(lim == CODE_W'(c), "R7 full", int'(lim), c);
      check(done == 1'b1, "R6 sticky", int'(done), 1);
    end

    // R2 R9: re-enter high impedance, then R7 R8 with moving code
    @(negedge clk);
    hiz = 1'b1;
    #1;
    check(lim == 0 && done == 0, "R2 re-entry", int'(lim), 0);
    repeat (4) @(negedge clk);
    hiz = 1'b0;
    run_ramp(T_RAMP + 20, 1'b1, "R8 moving");

    // R9: abort during the 50 percent step, restart must redo the hold
    @(negedge clk);
    hiz = 1'b1;
    @(negedge clk);
    hiz = 1'b0;
    code = 8'd255;
    run_ramp(T_HOLD + 5, 1'b0, "R9 first");
    @(negedge clk);
    hiz = 1'b1;
    #1;
    check(lim == 0, "R9 abort", int'(lim), 0);
    @(negedge clk);
    hiz = 1'b0;
    run_ramp(T_RAMP + 10, 1'b0, "R9 restart");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule